// File: doc/BRIEF.md
# Paged Logical-to-Physical Address Mapper

This block sits between a CPU with a 16-bit logical address and a 2 MiB physical bus. The logical space is cut into eight windows of 8 KiB each. Every window has its own 8-bit page register, and the top three logical address bits pick which register supplies the page number. That page number is placed above the 13 low logical bits, which gives a 21-bit physical address. The top two page bits and the middle three page bits are driven on separate extension line groups. The low three page bits sit on the upper conventional address lines.

The CPU reaches the page registers as eight consecutive bytes in its own memory space. A mode input picks one of two byte ranges for them: 8000h–8007h in compatibility mode, and F110h–F117h in native mode. A byte address ending in n selects register n, which serves logical window n×2000h. A CPU access that lands on the register range is handled by the block alone and is not passed to the physical bus. Every other access is translated and flagged as a bus access.

At reset, register n loads F0h+n, so every window starts on a boot ROM page.

Top module: `page_mapper`

## Requirements
- R1: After reset, page register n holds F0h+n for n = 0..7. This can be read back through the register range.
- R2: The physical address is formed from the page number of register cpu_addr[15:13] followed by cpu_addr[12:0]. The 21-bit result is {ext_top, ext_mid, phys_addr}.
- R3: In native mode (compat_mode=0), a write to F110h+n loads cpu_wdata into register n at the next rising clock. The other registers keep their values.
- R4: In compatibility mode (compat_mode=1), a write to 8000h+n loads cpu_wdata into register n at the next rising clock.
- R5: The register range of the inactive mode is not decoded. A write there changes no register and is issued as a normal translated bus access.
- R6: While cpu_rd is high and the address hits the active register range, cpu_rdata shows register cpu_addr[2:0] in the same cycle. Otherwise cpu_rdata is 00h.
- R7: An access that hits the active register range keeps phys_valid low.
- R8: phys_valid is high exactly when cpu_rd or cpu_wr is high and the address is outside the active register range.
- R9: Page bits [2:0] drive phys_addr[15:13], page bits [5:3] drive ext_mid[2:0], and page bits [7:6] drive ext_top[1:0]. For example, page BAh in window 4000h gives ext_top=2, ext_mid=7 and phys_addr[15:13]=2.
- R10: A cycle without cpu_wr changes no page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_mode | input | 1 | 1 selects the 8000h register range, 0 selects F110h |
| cpu_addr | input | 16 | CPU logical byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Register read data, 00h when not reading a register |
| phys_addr | output | 16 | Conventional physical address lines |
| ext_mid | output | 3 | Middle extension lines (page bits 5:3) |
| ext_top | output | 2 | Top extension lines (page bits 7:6) |
| phys_valid | output | 1 | A translated bus access is being issued |

## Verification
A corrupted page register shows up on the address lines the first time the CPU touches the window that register serves. It also shows up on a read-back of that register in the same cycle. Because the mapping is combinational, a bad write or a missed write appears on the very next cycle whose address falls in the affected window. A wrong range decode shows up at once in two ways: phys_valid is asserted for a register access, or a bus write quietly alters a page register. To catch each of these without delay, the bench sweeps addresses across all eight windows and both register ranges every cycle.

// File: rtl/page_map_pkg.sv
package page_map_pkg;
   localparam int unsigned PM_LADDR_W = 16;
   localparam int unsigned PM_WIN_BITS = 3;
   localparam int unsigned PM_PAGE_W = 8;

   function automatic logic [PM_PAGE_W-1:0] boot_page(input int unsigned base, input int unsigned n);
      return PM_PAGE_W'(base + n);
   endfunction
endpackage

// File: rtl/map_page_regs.sv
module map_page_regs
   import page_map_pkg::*;
#(
   parameter int unsigned NREG     = 8,
   parameter int unsigned PAGE_W   = 8,
   parameter int unsigned RST_BASE = 'hF0,
   localparam int unsigned IDX_W   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [PAGE_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  xl_idx,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [PAGE_W-1:0] xl_page,
   output logic [PAGE_W-1:0] rd_page
);
   logic [NREG-1:0][PAGE_W-1:0] pages;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pages[g] <= boot_page(RST_BASE, g);
         else if (wr_en && (wr_idx == IDX_W'(g)))
            pages[g] <= wr_data;
      end
   end

   assign xl_page = pages[xl_idx];
   assign rd_page = pages[rd_idx];

   // R3 / R4: selected register takes the written byte
   p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> pages[$past(wr_idx)] == $past(wr_data));
   // R10: no write, no change
   p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(pages));
endmodule

// File: rtl/map_window_decode.sv
module map_window_decode #(
   parameter int unsigned LADDR_W     = 16,
   parameter int unsigned WIN_BITS    = 3,
   parameter logic [15:0] NATIVE_BASE = 16'hF110,
   parameter logic [15:0] COMPAT_BASE = 16'h8000
) (
   input  logic               compat_mode,
   input  logic [LADDR_W-1:0] addr,
   output logic               hit,
   output logic [WIN_BITS-1:0] idx
);
   localparam int unsigned TAG_W = LADDR_W - WIN_BITS;
   localparam logic [1:0][LADDR_W-1:0] BASES = {LADDR_W'(COMPAT_BASE), LADDR_W'(NATIVE_BASE)};

   logic [1:0] match;

   for (genvar m = 0; m < 2; m++) begin : g_mode
      if (BASES[m][WIN_BITS-1:0] != '0) begin : g_bad
         $error("register range base must be aligned to the register count");
      end
      assign match[m] = (addr[LADDR_W-1:WIN_BITS] == BASES[m][LADDR_W-1:WIN_BITS]);
   end

   assign hit = compat_mode ? match[1] : match[0];
   assign idx = addr[WIN_BITS-1:0];

   logic [TAG_W-1:0] unused_tag;
   assign unused_tag = addr[LADDR_W-1:WIN_BITS];
endmodule

// File: rtl/map_translate.sv
module map_translate #(
   parameter int unsigned LADDR_W  = 16,
   parameter int unsigned WIN_BITS = 3,
   parameter int unsigned PAGE_W   = 8,
   parameter int unsigned MID_W    = 3,
   localparam int unsigned OFF_W   = LADDR_W - WIN_BITS,
   localparam int unsigned TOP_W   = PAGE_W - WIN_BITS - MID_W
) (
   input  logic [PAGE_W-1:0]  page,
   input  logic [OFF_W-1:0]   offset,
   output logic [LADDR_W-1:0] conv,
   output logic [MID_W-1:0]   ext_mid,
   output logic [TOP_W-1:0]   ext_top
);
   if (TOP_W < 1) begin : g_chk
      $error("page width too small for the extension groups");
   end

   assign conv    = {page[WIN_BITS-1:0], offset};
   assign ext_mid = page[WIN_BITS +: MID_W];
   assign ext_top = page[PAGE_W-1 -: TOP_W];
endmodule

// File: rtl/page_mapper.sv
module page_mapper
   import page_map_pkg::*;
#(
   parameter int unsigned LADDR_W     = PM_LADDR_W,
   parameter int unsigned WIN_BITS    = PM_WIN_BITS,
   parameter int unsigned PAGE_W      = PM_PAGE_W,
   parameter int unsigned MID_W       = 3,
   parameter logic [15:0] NATIVE_BASE = 16'hF110,
   parameter logic [15:0] COMPAT_BASE = 16'h8000,
   parameter int unsigned RST_BASE    = 'hF0,
   localparam int unsigned NREG       = 1 << WIN_BITS,
   localparam int unsigned OFF_W      = LADDR_W - WIN_BITS,
   localparam int unsigned TOP_W      = PAGE_W - WIN_BITS - MID_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               compat_mode,
   input  logic [LADDR_W-1:0] cpu_addr,
   input  logic               cpu_wr,
   input  logic               cpu_rd,
   input  logic [PAGE_W-1:0]  cpu_wdata,
   output logic [PAGE_W-1:0]  cpu_rdata,
   output logic [LADDR_W-1:0] phys_addr,
   output logic [MID_W-1:0]   ext_mid,
   output logic [TOP_W-1:0]   ext_top,
   output logic               phys_valid
);
   if (LADDR_W != 16 || WIN_BITS > 8) begin : g_chk
      $error("logical address width must be 16 with at most 8 window bits");
   end

   logic                reg_hit;
   logic [WIN_BITS-1:0] reg_idx;
   logic [PAGE_W-1:0]   xl_page, rd_page;

   map_window_decode #(
      .LADDR_W(LADDR_W), .WIN_BITS(WIN_BITS),
      .NATIVE_BASE(NATIVE_BASE), .COMPAT_BASE(COMPAT_BASE)
   ) u_dec (
      .compat_mode(compat_mode), .addr(cpu_addr), .hit(reg_hit), .idx(reg_idx)
   );

   map_page_regs #(.NREG(NREG), .PAGE_W(PAGE_W), .RST_BASE(RST_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cpu_wr && reg_hit), .wr_idx(reg_idx), .wr_data(cpu_wdata),
      .xl_idx(cpu_addr[LADDR_W-1 -: WIN_BITS]), .rd_idx(reg_idx),
      .xl_page(xl_page), .rd_page(rd_page)
   );

   map_translate #(
      .LADDR_W(LADDR_W), .WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W), .MID_W(MID_W)
   ) u_xl (
      .page(xl_page), .offset(cpu_addr[OFF_W-1:0]),
      .conv(phys_addr), .ext_mid(ext_mid), .ext_top(ext_top)
   );

   assign cpu_rdata  = (cpu_rd && reg_hit) ? rd_page : '0;
   assign phys_valid = (cpu_rd || cpu_wr) && !reg_hit;

   // R7: register accesses never reach the bus
   p_no_bus_on_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && reg_hit) |-> !phys_valid);
   // R6: idle read port is zero
   p_rdata_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |-> cpu_rdata == '0);
   // R6: read after write to same register returns the written byte
   p_read_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && reg_hit) |=>
         ((cpu_rd && cpu_addr == $past(cpu_addr) && compat_mode == $past(compat_mode))
            |-> cpu_rdata == $past(cpu_wdata)));
   // R2: offset bits pass straight through
   p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phys_valid |-> phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);
endmodule

// File: tb/page_mapper_test.sv
`timescale 1ns/1ps
module page_mapper_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst_n = 0, compat_mode = 0;
   logic [15:0] cpu_addr = 0;
   logic cpu_wr = 0, cpu_rd = 0;
   logic [7:0] cpu_wdata = 0;
   logic [7:0] cpu_rdata;
   logic [15:0] phys_addr;
   logic [2:0] ext_mid;
   logic [1:0] ext_top;
   logic phys_valid;

   int checks = 0, fails = 0;
   int model [8];
   bit done = 0;

   page_mapper uut (
      .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode), .cpu_addr(cpu_addr),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .phys_addr(phys_addr), .ext_mid(ext_mid), .ext_top(ext_top), .phys_valid(phys_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (addr=%0h mode=%0b)", req, act, exp, cpu_addr, compat_mode);
      end
   endtask

   function automatic bit in_window(input logic [15:0] a, input logic m);
      int base = m ? 'h8000 : 'hF110;
      return (int'(a) >= base) && (int'(a) < base + 8);
   endfunction

   // Drive one cycle, compare against the model, then advance the model at the edge.
   task automatic cycle(input logic [15:0] a, input logic wr, input logic rd,
                        input logic [7:0] wd, input logic m);
      bit hit;
      int pg;
      @(negedge clk);
      cpu_addr = a; cpu_wr = wr; cpu_rd = rd; cpu_wdata = wd; compat_mode = m;
      #1;
      hit = in_window(a, m);
      pg  = model[a[15:13]];
      check("R2 offset", phys_addr[12:0], a[12:0]);
      check("R9 conventional page bits", phys_addr[15:13], pg & 7);
      check("R9 ext_mid", ext_mid, (pg >> 3) & 7);
      check("R9 ext_top", ext_top, (pg >> 6) & 3);
      check(hit ? "R7 no bus on register access" : "R8 bus valid", phys_valid, (rd || wr) && !hit);
      check("R6 read data", cpu_rdata, (rd && hit) ? model[a[2:0]] : 0);
      @(posedge clk);
      if (wr && hit) model[a[2:0]] = wd;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) model[i] = 'hF0 + i;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: reset contents visible through the native range
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); cpu_addr = 16'hF110 + 16'(i); cpu_rd = 1; cpu_wr = 0; compat_mode = 0;
         #1 check("R1 reset value", cpu_rdata, 'hF0 + i);
      end
      // R3: native write, example page BAh to window 4000h
      cycle(16'hF112, 1, 0, 8'hBA, 0);
      cycle(16'h4123, 0, 1, 8'h00, 0);
      check("R9 example ext_top", ext_top, 2);
      check("R9 example ext_mid", ext_mid, 7);
      check("R9 example conv", phys_addr[15:13], 2);
      cycle(16'hF111, 0, 1, 8'h00, 0);      // R3 neighbour untouched
      // R4: compat write
      cycle(16'h8007, 1, 0, 8'h3C, 1);
      cycle(16'hE000, 0, 1, 8'h00, 1);
      cycle(16'h8007, 0, 1, 8'h00, 1);
      // R5: inactive range is a plain bus access
      cycle(16'h8005, 1, 0, 8'h11, 0);
      cycle(16'hF115, 1, 0, 8'h22, 1);
      cycle(16'hF115, 0, 1, 8'h00, 0);
      check("R5 no register change", cpu_rdata, 'hF5);
      // R10: read without write, then idle
      cycle(16'h8003, 0, 1, 8'hFF, 1);
      cycle(16'h8003, 0, 0, 8'hFF, 1);
      cycle(16'h8003, 0, 1, 8'h00, 1);
      check("R10 hold", cpu_rdata, 'hF3);
      // random mix biased towards the register ranges
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         int sel = $urandom_range(0, 3);
         logic m = 1'($urandom_range(0, 1));
         a = (sel == 0) ? 16'hF110 + 16'($urandom_range(0, 9)) - 16'd1 :
             (sel == 1) ? 16'h8000 + 16'($urandom_range(0, 9)) - 16'd1 : 16'($urandom);
         cycle(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom), m);
      end
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule